// File: doc/BRIEF.md
# Branch Rename Checkpoint Stack

This block keeps the live rename map of an out-of-order core. For each logical register, the map holds the reorder-entry tag of the newest producer and a "value in register file" bit. At every dispatched branch it copies the live map into a free checkpoint slot. The same slot also saves the reorder tail index that follows the branch. The slots form a last-in, first-out stack.

When the newest outstanding branch resolves as mispredicted, the block pops its slot and restores the live map from it. It then reports the saved tail index, so that the reorder queue can drop wrong-path entries at once instead of waiting for the branch to retire. A correctly predicted branch frees its slot and leaves the map unchanged.

The slow recovery path is a separate flush input. It is used once a mispredicted branch has reached the queue head. It empties the stack and marks every register as held in the register file.

Top module: `rename_ckpt_stack`

## Requirements
- R1: After reset every map tag is 0, every "in register file" bit is 1, `br_stall` is 0 and `tail_fix_valid` is 0.
- R2: A rename (`ren_valid`) writes `ren_tag` into the entry of `ren_lreg` and clears its "in register file" bit, visible on the outputs one cycle later.
- R3: A writeback sets the "in register file" bit of `wb_lreg` only when the entry's tag equals `wb_tag`; a writeback with a different tag leaves the bit unchanged.
- R4: A branch (`br_valid`) saves the map as it stood before any rename of the same cycle, together with `br_tail`; the same-cycle rename still updates the live map.
- R5: A mispredict (`resolve_valid` and `resolve_mispredict`) with at least one checkpoint restores the newest checkpoint into the live map and pops it. One cycle later, `tail_fix_valid` pulses for one cycle and `tail_fix` carries that checkpoint's saved tail. A rename in the mispredict cycle is dropped.
- R6: A correct resolve (`resolve_valid` with `resolve_mispredict` low) pops the newest checkpoint and leaves the live map unchanged. A later mispredict then restores the checkpoint below it.
- R7: With DEPTH checkpoints held, `br_stall` is 1 and a branch is ignored, so that branch saves no checkpoint.
- R8: `flush_all` sets every "in register file" bit to 1 and empties the stack. A following mispredict produces no `tail_fix_valid`.
- R9: A writeback also sets the "in register file" bit inside every held checkpoint whose saved tag for `wb_lreg` equals `wb_tag`, so a later restore shows that register as ready.
- R10: A resolve while the stack is empty changes neither the map nor the tail outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename write this cycle |
| ren_lreg | input | LREG_W | Logical register being renamed |
| ren_tag | input | TAG_W | Reorder-entry tag of the new producer |
| br_valid | input | 1 | Branch dispatched, take a checkpoint |
| br_tail | input | TAG_W | Reorder tail index just after the branch |
| br_stall | output | 1 | Stack full, branch dispatch must wait |
| resolve_valid | input | 1 | Newest outstanding branch resolved |
| resolve_mispredict | input | 1 | Resolved branch was mispredicted |
| wb_valid | input | 1 | Result writeback |
| wb_lreg | input | LREG_W | Destination logical register of the writeback |
| wb_tag | input | TAG_W | Reorder-entry tag of the writing instruction |
| flush_all | input | 1 | Slow recovery: clear stack, all values in register file |
| map_tags | output | NUM_LREGS*TAG_W | Live map tags, register r at bits r*TAG_W upward |
| map_in_rf | output | NUM_LREGS | Live "in register file" bits, one per register |
| tail_fix_valid | output | 1 | One-cycle pulse: set the reorder tail |
| tail_fix | output | TAG_W | Tail index to restore |

## Verification
A corrupted checkpoint slot or stack count stays hidden until a mispredict or the stall output exposes it. At that point the wrong tags or tail index appear on `map_tags` and `tail_fix` exactly one cycle after the resolve. A live-map fault caused by a bad writeback comparison shows up on `map_in_rf` in the cycle after the writeback. Each test therefore takes checkpoints, changes the live map, and then triggers a restore, so that slot contents are driven out to the ports.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef enum logic [2:0] {
        STK_HOLD,
        STK_PUSH,
        STK_RELEASE,
        STK_SWAP,
        STK_RESTORE,
        STK_FLUSH
    } stk_op_e;
endpackage

// File: rtl/rcs_slot.sv
module rcs_slot #(
    parameter int NUM_LREGS = 8,
    parameter int TAG_W     = 4,
    localparam int LREG_W   = $clog2(NUM_LREGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic [NUM_LREGS*TAG_W-1:0] load_tags,
    input  logic [NUM_LREGS-1:0]       load_inrf,
    input  logic [TAG_W-1:0]           load_tail,
    input  logic                       wb_valid,
    input  logic [LREG_W-1:0]          wb_lreg,
    input  logic [TAG_W-1:0]           wb_tag,
    output logic [NUM_LREGS*TAG_W-1:0] slot_tags,
    output logic [NUM_LREGS-1:0]       slot_inrf,
    output logic [TAG_W-1:0]           slot_tail
);
    typedef struct packed {
        logic [NUM_LREGS-1:0][TAG_W-1:0] tags;
        logic [NUM_LREGS-1:0]            inrf;
        logic [TAG_W-1:0]                tail;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (load_en) begin
            slot_d.tags = load_tags;
            slot_d.inrf = load_inrf;
            slot_d.tail = load_tail;
        end
        // a result landing this cycle also marks the saved copy ready
        if (wb_valid && slot_d.tags[wb_lreg] == wb_tag) begin
            slot_d.inrf[wb_lreg] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q.tags <= '0;
            slot_q.inrf <= '1;
            slot_q.tail <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot_tags = slot_q.tags;
    assign slot_inrf = slot_q.inrf;
    assign slot_tail = slot_q.tail;
endmodule

// File: rtl/rcs_live_map.sv
module rcs_live_map #(
    parameter int NUM_LREGS = 8,
    parameter int TAG_W     = 4,
    localparam int LREG_W   = $clog2(NUM_LREGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_en,
    input  logic                       restore_en,
    input  logic [NUM_LREGS*TAG_W-1:0] restore_tags,
    input  logic [NUM_LREGS-1:0]       restore_inrf,
    input  logic                       wb_valid,
    input  logic [LREG_W-1:0]          wb_lreg,
    input  logic [TAG_W-1:0]           wb_tag,
    input  logic                       ren_en,
    input  logic [LREG_W-1:0]          ren_lreg,
    input  logic [TAG_W-1:0]           ren_tag,
    output logic [NUM_LREGS*TAG_W-1:0] live_tags,
    output logic [NUM_LREGS-1:0]       live_inrf
);
    typedef struct packed {
        logic [NUM_LREGS-1:0][TAG_W-1:0] tags;
        logic [NUM_LREGS-1:0]            inrf;
    } map_t;

    map_t map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (flush_en) begin
            map_d.inrf = '1;
        end else begin
            if (restore_en) begin
                map_d.tags = restore_tags;
                map_d.inrf = restore_inrf;
            end
            if (wb_valid && map_d.tags[wb_lreg] == wb_tag) begin
                map_d.inrf[wb_lreg] = 1'b1;
            end
            // the new producer wins over a same-cycle result
            if (ren_en) begin
                map_d.tags[ren_lreg] = ren_tag;
                map_d.inrf[ren_lreg] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q.tags <= '0;
            map_q.inrf <= '1;
        end else begin
            map_q <= map_d;
        end
    end

    assign live_tags = map_q.tags;
    assign live_inrf = map_q.inrf;
endmodule

// File: rtl/rename_ckpt_stack.sv
module rename_ckpt_stack #(
    parameter int NUM_LREGS = 8,
    parameter int TAG_W     = 4,
    parameter int DEPTH     = 4,
    localparam int LREG_W   = $clog2(NUM_LREGS),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int MAP_W    = NUM_LREGS * TAG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ren_valid,
    input  logic [LREG_W-1:0]    ren_lreg,
    input  logic [TAG_W-1:0]     ren_tag,
    input  logic                 br_valid,
    input  logic [TAG_W-1:0]     br_tail,
    output logic                 br_stall,
    input  logic                 resolve_valid,
    input  logic                 resolve_mispredict,
    input  logic                 wb_valid,
    input  logic [LREG_W-1:0]    wb_lreg,
    input  logic [TAG_W-1:0]     wb_tag,
    input  logic                 flush_all,
    output logic [MAP_W-1:0]     map_tags,
    output logic [NUM_LREGS-1:0] map_in_rf,
    output logic                 tail_fix_valid,
    output logic [TAG_W-1:0]     tail_fix
);
    import rcs_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fix_vld;
        logic [TAG_W-1:0] fix_tail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    stk_op_e op;

    logic [DEPTH-1:0][MAP_W-1:0]     slot_tags;
    logic [DEPTH-1:0][NUM_LREGS-1:0] slot_inrf;
    logic [DEPTH-1:0][TAG_W-1:0]     slot_tail;

    logic             has_ckpt, full;
    logic [PTR_W-1:0] top_idx, push_idx;
    logic             push_en, restore_en, flush_en, ren_en;

    assign has_ckpt = (ctl_q.cnt != '0);
    assign full     = (ctl_q.cnt == CNT_W'(DEPTH));
    assign top_idx  = PTR_W'(ctl_q.cnt - 1'b1);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.fix_vld = 1'b0;
        op            = STK_HOLD;
        push_idx      = PTR_W'(ctl_q.cnt);
        if (flush_all) begin
            op        = STK_FLUSH;
            ctl_d.cnt = '0;
        end else if (resolve_valid && resolve_mispredict && has_ckpt) begin
            op             = STK_RESTORE;
            ctl_d.cnt      = ctl_q.cnt - 1'b1;
            ctl_d.fix_vld  = 1'b1;
            ctl_d.fix_tail = slot_tail[top_idx];
        end else begin
            case ({resolve_valid && has_ckpt, br_valid && !full})
                2'b11: begin
                    op       = STK_SWAP;
                    push_idx = top_idx;
                end
                2'b10: begin
                    op        = STK_RELEASE;
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
                2'b01: begin
                    op        = STK_PUSH;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
                default: op = STK_HOLD;
            endcase
        end
        push_en    = (op == STK_PUSH) || (op == STK_SWAP);
        restore_en = (op == STK_RESTORE);
        flush_en   = (op == STK_FLUSH);
        ren_en     = ren_valid && !restore_en && !flush_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.cnt      <= '0;
            ctl_q.fix_vld  <= 1'b0;
            ctl_q.fix_tail <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rcs_slot #(
            .NUM_LREGS(NUM_LREGS),
            .TAG_W    (TAG_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (push_en && (push_idx == PTR_W'(g))),
            .load_tags(map_tags),
            .load_inrf(map_in_rf),
            .load_tail(br_tail),
            .wb_valid (wb_valid && !flush_en),
            .wb_lreg  (wb_lreg),
            .wb_tag   (wb_tag),
            .slot_tags(slot_tags[g]),
            .slot_inrf(slot_inrf[g]),
            .slot_tail(slot_tail[g])
        );
    end

    rcs_live_map #(
        .NUM_LREGS(NUM_LREGS),
        .TAG_W    (TAG_W)
    ) u_live (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_en    (flush_en),
        .restore_en  (restore_en),
        .restore_tags(slot_tags[top_idx]),
        .restore_inrf(slot_inrf[top_idx]),
        .wb_valid    (wb_valid),
        .wb_lreg     (wb_lreg),
        .wb_tag      (wb_tag),
        .ren_en      (ren_en),
        .ren_lreg    (ren_lreg),
        .ren_tag     (ren_tag),
        .live_tags   (map_tags),
        .live_inrf   (map_in_rf)
    );

    assign br_stall       = full;
    assign tail_fix_valid = ctl_q.fix_vld;
    assign tail_fix       = ctl_q.fix_tail;
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
    parameter int NUM_LREGS = 8,
    parameter int TAG_W     = 4,
    localparam int LREG_W   = $clog2(NUM_LREGS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ren_valid,
    input logic [LREG_W-1:0]          ren_lreg,
    input logic [TAG_W-1:0]           ren_tag,
    input logic                       br_stall,
    input logic                       resolve_valid,
    input logic                       resolve_mispredict,
    input logic                       wb_valid,
    input logic [LREG_W-1:0]          wb_lreg,
    input logic [TAG_W-1:0]           wb_tag,
    input logic                       flush_all,
    input logic [NUM_LREGS*TAG_W-1:0] map_tags,
    input logic [NUM_LREGS-1:0]       map_in_rf,
    input logic                       tail_fix_valid
);
    logic mis_req;
    assign mis_req = resolve_valid && resolve_mispredict;

    p_rename_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid && !mis_req && !flush_all
        |=> map_tags[$past(ren_lreg)*TAG_W +: TAG_W] == $past(ren_tag)
            && !map_in_rf[$past(ren_lreg)]);

    p_wb_nomatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && (map_tags[wb_lreg*TAG_W +: TAG_W] != wb_tag)
        && !ren_valid && !resolve_valid && !flush_all
        |=> map_in_rf[$past(wb_lreg)] == $past(map_in_rf[wb_lreg]));

    p_fix_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tail_fix_valid |-> $past(mis_req && !flush_all));

    p_map_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_valid && !mis_req && !flush_all |=> $stable(map_tags));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        br_stall && !resolve_valid && !flush_all |=> br_stall);

    p_flush_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (&map_in_rf) && !tail_fix_valid);
endmodule

bind rename_ckpt_stack rcs_checker #(
    .NUM_LREGS(NUM_LREGS),
    .TAG_W    (TAG_W)
) u_rcs_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .ren_valid         (ren_valid),
    .ren_lreg          (ren_lreg),
    .ren_tag           (ren_tag),
    .br_stall          (br_stall),
    .resolve_valid     (resolve_valid),
    .resolve_mispredict(resolve_mispredict),
    .wb_valid          (wb_valid),
    .wb_lreg           (wb_lreg),
    .wb_tag            (wb_tag),
    .flush_all         (flush_all),
    .map_tags          (map_tags),
    .map_in_rf         (map_in_rf),
    .tail_fix_valid    (tail_fix_valid)
);

// File: tb/rename_ckpt_stack_bench.sv
`timescale 1ns/1ps
module rename_ckpt_stack_bench;
    localparam int NL = 8;
    localparam int TW = 4;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_valid, br_valid, resolve_valid, resolve_mispredict;
    logic          wb_valid, flush_all, br_stall, tail_fix_valid;
    logic [2:0]    ren_lreg, wb_lreg;
    logic [TW-1:0] ren_tag, br_tail, wb_tag, tail_fix;
    logic [NL*TW-1:0] map_tags;
    logic [NL-1:0] map_in_rf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rename_ckpt_stack #(.NUM_LREGS(NL), .TAG_W(TW), .DEPTH(DP)) u_rename_ckpt_stack (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_lreg(ren_lreg), .ren_tag(ren_tag),
        .br_valid(br_valid), .br_tail(br_tail), .br_stall(br_stall),
        .resolve_valid(resolve_valid), .resolve_mispredict(resolve_mispredict),
        .wb_valid(wb_valid), .wb_lreg(wb_lreg), .wb_tag(wb_tag),
        .flush_all(flush_all), .map_tags(map_tags), .map_in_rf(map_in_rf),
        .tail_fix_valid(tail_fix_valid), .tail_fix(tail_fix)
    );

    function automatic int tag_of(int r);
        return int'(map_tags[r*TW +: TW]);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ren_valid = 0; ren_lreg = 0; ren_tag = 0;
        br_valid = 0; br_tail = 0;
        resolve_valid = 0; resolve_mispredict = 0;
        wb_valid = 0; wb_lreg = 0; wb_tag = 0;
        flush_all = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic rename(int r, int t);
        ren_valid = 1; ren_lreg = 3'(r); ren_tag = TW'(t);
        cyc();
    endtask

    task automatic branch(int tail);
        br_valid = 1; br_tail = TW'(tail);
        cyc();
    endtask

    task automatic resolve(bit mis);
        resolve_valid = 1; resolve_mispredict = mis;
        cyc();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 in_rf", int'(map_in_rf), 255);
        check("R1 tags", int'(map_tags), 0);
        check("R1 stall", int'(br_stall), 0);
        check("R1 fix", int'(tail_fix_valid), 0);
    endtask

    task automatic t_rename_wb();
        do_reset();
        rename(3, 5);
        check("R2 tag", tag_of(3), 5);
        check("R2 in_rf", int'(map_in_rf[3]), 0);
        wb_valid = 1; wb_lreg = 3; wb_tag = 6;
        cyc();
        check("R3 mismatch ignored", int'(map_in_rf[3]), 0);
        wb_valid = 1; wb_lreg = 3; wb_tag = 5;
        cyc();
        check("R3 match sets", int'(map_in_rf[3]), 1);
    endtask

    task automatic t_branch_restore();
        do_reset();
        rename(1, 2);
        br_valid = 1; br_tail = 7;
        ren_valid = 1; ren_lreg = 1; ren_tag = 9;
        cyc();
        check("R4 live rename", tag_of(1), 9);
        rename(2, 10);
        resolve_valid = 1; resolve_mispredict = 1;
        ren_valid = 1; ren_lreg = 4; ren_tag = 11;
        cyc();
        check("R4 restored pre-rename tag", tag_of(1), 2);
        check("R5 tag2 restored", tag_of(2), 0);
        check("R5 in_rf2 restored", int'(map_in_rf[2]), 1);
        check("R5 rename dropped", tag_of(4), 0);
        check("R5 fix valid", int'(tail_fix_valid), 1);
        check("R5 fix tail", int'(tail_fix), 7);
        cyc();
        check("R5 fix pulse ends", int'(tail_fix_valid), 0);
    endtask

    task automatic t_release();
        do_reset();
        branch(3);
        rename(0, 4);
        branch(8);
        rename(0, 12);
        resolve(1'b0);
        check("R6 map kept", tag_of(0), 12);
        check("R6 no fix", int'(tail_fix_valid), 0);
        resolve(1'b1);
        check("R6 lower restored", tag_of(0), 0);
        check("R6 lower tail", int'(tail_fix), 3);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 1; i <= DP; i++) branch(i);
        check("R7 stall", int'(br_stall), 1);
        branch(9);
        check("R7 still stall", int'(br_stall), 1);
        resolve(1'b1);
        check("R7 ignored branch", int'(tail_fix), DP);
        check("R7 stall clears", int'(br_stall), 0);
    endtask

    task automatic t_flush();
        do_reset();
        rename(6, 3);
        branch(5);
        flush_all = 1;
        cyc();
        check("R8 all ready", int'(map_in_rf), 255);
        resolve(1'b1);
        check("R8 stack empty", int'(tail_fix_valid), 0);
    endtask

    task automatic t_empty();
        do_reset();
        rename(5, 7);
        resolve(1'b1);
        check("R10 no fix", int'(tail_fix_valid), 0);
        check("R10 map kept", tag_of(5), 7);
        resolve(1'b0);
        check("R10 release empty", tag_of(5), 7);
    endtask

    task automatic t_ckpt_wb();
        do_reset();
        rename(7, 6);
        branch(2);
        rename(7, 14);
        wb_valid = 1; wb_lreg = 7; wb_tag = 6;
        cyc();
        check("R3 live stale tag", int'(map_in_rf[7]), 0);
        resolve(1'b1);
        check("R9 tag restored", tag_of(7), 6);
        check("R9 ready in ckpt", int'(map_in_rf[7]), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rename_wb();
        t_branch_restore();
        t_release();
        t_full();
        t_flush();
        t_empty();
        t_ckpt_wb();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule